// File: doc/BRIEF.md
# Capture/Compare Timer with Prescaler

A 32-bit up-counter with a 16-bit mode register. The counter advances on strobes from a selectable source: stopped, every system clock, every sixteenth system clock, or falling edges of the external timer input. An 8-bit prescaler sits between the source and the counter. A reference register is compared with the count. A match sets a sticky reference flag and drives the timer output pin, either as a one-cycle low pulse or as a toggle. A match can also restart the count.

A chosen edge on the timer input copies the live count into a capture register and sets a sticky capture flag. Both flags can raise a request. A routing bit sends that request to the DMA request output or to the interrupt output. Software sets up the block through a single-cycle register write port. Register reads are combinational.

Register map (3-bit address): 0 mode, 1 reference, 2 capture (read-only), 3 counter (read-only), 4 event flags, 5 request routing. Addresses 6 and 7 read as zero.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, every register reads zero, the timer output is high, and both the interrupt and the DMA request are low.
- R2: Mode bits 15:8 hold a prescale value P. The counter advances once for every P+1 strobes of the selected source.
- R3: Mode bits 2:1 select the source: 00 stops the count, 01 gives every system clock, 10 gives every 16th system clock, and 11 gives falling edges of the timer input.
- R4: Mode bit 0 is the run bit. While it is 0 the counter reads zero. A write that changes it from 1 to 0 also clears the reference, capture and flag registers, and stores the new mode value as written.
- R5: A mode write made while the run bit is already 1 stores 00 in bits 2:1, so the count freezes.
- R6: A reference event happens on the source tick that takes the count to the reference value. It sets event bit 0. With mode bit 3 at 0 the count keeps incrementing past the reference value.
- R7: With mode bit 3 at 1, the tick that matches loads zero in place of the reference value.
- R8: With mode bit 5 at 0, the timer output goes low for exactly one system clock after each reference event.
- R9: With mode bit 5 at 1, the timer output inverts after each reference event.
- R10: A request is active when event bit 0 and mode bit 4 are both set, or when event bit 1 is set. Mode bit 4 has no effect on the request from a capture. The request drives the DMA request when routing bit 0 is 1, and the interrupt when that bit is 0.
- R11: Mode bits 7:6 select the capture edge: 00 off, 01 rising, 10 falling, 11 both. The input passes through two synchronizer flops, so the count captured is the value held two clocks after the pin changes.
- R12: A capture loads the counter into the capture register and sets event bit 1. Writing 1 to an event bit clears that bit. A capture in the same cycle as a clear of bit 1 leaves bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| tmr_pin_i | input | 1 | External timer input |
| tmr_pin_o | output | 1 | Timer output |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The bench measures exact tick counts for prescale 3, for the divide-by-16 source and for pin edges. A prescaler that is off by one, or that divides by P instead of P+1, ends on the wrong count. It drives the capture edge so that it lands on the same clock as a flag clear. A design that lets the clear win loses the capture flag. Fixed capture values expose a synchronizer with the wrong latency, and a restart that loads the reference value instead of zero shows up in the count. It also rewrites the mode while the timer runs and checks that the count freezes. It disables the timer and checks that every register is cleared, which catches a counter or capture register that survives the disable.

// File: rtl/capcmp_timer_pkg.sv
package capcmp_timer_pkg;

  localparam int unsigned MODE_W = 16;
  localparam int unsigned PSC_W  = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    CLK_STOP  = 2'b00,
    CLK_SYS   = 2'b01,
    CLK_SYS16 = 2'b10,
    CLK_PIN   = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_edge_e;

  // field order follows bit positions 15..0
  typedef struct packed {
    logic [PSC_W-1:0] psc;
    cap_edge_e        cap_edge;
    logic             toggle;
    logic             ref_req_en;
    logic             restart;
    clk_sel_e         clk_sel;
    logic             run;
  } mode_t;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_REF   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_ROUTE = 3'd5;

endpackage

// File: rtl/ccmp_pin_sync.sv
module ccmp_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= (g == 0) ? pin_i : sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R11
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R11

endmodule

// File: rtl/ccmp_tick_gen.sv
module ccmp_tick_gen
  import capcmp_timer_pkg::*;
#(
  parameter int unsigned PS_W     = 8,
  parameter int unsigned SLOW_DIV = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  clk_sel_e        clk_sel_i,
  input  logic [PS_W-1:0] psc_i,
  input  logic            pin_fall_i,
  output logic            tick_o
);

  localparam int unsigned SLOW_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV - 1);

  logic [SLOW_W-1:0] slow_q;
  logic [PS_W-1:0]   psc_q;
  logic              slow_stb, src_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                slow_q <= '0;
    else if (!run_i)            slow_q <= '0;
    else if (slow_q == SLOW_LAST) slow_q <= '0;
    else                        slow_q <= slow_q + 1'b1;
  end

  assign slow_stb = run_i && (slow_q == SLOW_LAST);

  always_comb begin
    unique case (clk_sel_i)
      CLK_SYS:   src_stb = run_i;
      CLK_SYS16: src_stb = slow_stb;
      CLK_PIN:   src_stb = run_i && pin_fall_i;
      default:   src_stb = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            psc_q <= '0;
    else if (!run_i)        psc_q <= '0;
    else if (src_stb) begin
      if (psc_q == psc_i)   psc_q <= '0;
      else                  psc_q <= psc_q + 1'b1;
    end
  end

  assign tick_o = src_stb && (psc_q == psc_i);

  AST_PRESCALE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_i != '0) |=> !tick_o); // R2

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SLOW_DIV    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tmr_pin_i,
  output logic              tmr_pin_o,
  output logic              irq_o,
  output logic              dma_req_o
);

  mode_t            mode_q, mode_wr, mode_d;
  logic [CNT_W-1:0] ref_q, cap_q, cnt_q, cnt_inc;
  logic             ref_flag_q, cap_flag_q, route_dma_q, out_q;
  logic             wr_mode, wr_ref, wr_evt, wr_route, run_fall;
  logic             tick, hit, cap_stb, pin_rise, pin_fall;
  logic             clr_ref, clr_cap, evt_req;

  assign wr_mode  = wr_en_i && (addr_i == A_MODE);
  assign wr_ref   = wr_en_i && (addr_i == A_REF);
  assign wr_evt   = wr_en_i && (addr_i == A_EVT);
  assign wr_route = wr_en_i && (addr_i == A_ROUTE);
  assign mode_wr  = mode_t'(wdata_i[MODE_W-1:0]);
  assign run_fall = wr_mode && mode_q.run && !mode_wr.run;
  assign clr_ref  = wr_evt && wdata_i[0];
  assign clr_cap  = wr_evt && wdata_i[1];

  // a mode write while running always stops the source
  always_comb begin
    mode_d = mode_wr;
    if (mode_q.run) mode_d.clk_sel = CLK_STOP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      route_dma_q <= 1'b0;
    end else begin
      if (wr_mode)  mode_q      <= mode_d;
      if (wr_route) route_dma_q <= wdata_i[0];
    end
  end

  ccmp_pin_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (tmr_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  ccmp_tick_gen #(.PS_W(PSC_W), .SLOW_DIV(SLOW_DIV)) i_tick_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (mode_q.run),
    .clk_sel_i  (mode_q.clk_sel),
    .psc_i      (mode_q.psc),
    .pin_fall_i (pin_fall),
    .tick_o     (tick)
  );

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = tick && (cnt_inc == ref_q);

  always_comb begin
    unique case (mode_q.cap_edge)
      CAP_RISE: cap_stb = pin_rise;
      CAP_FALL: cap_stb = pin_fall;
      CAP_BOTH: cap_stb = pin_rise | pin_fall;
      default:  cap_stb = 1'b0;
    endcase
    cap_stb = cap_stb && mode_q.run;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (run_fall || !mode_q.run)  cnt_q <= '0;
    else if (hit)                      cnt_q <= mode_q.restart ? '0 : cnt_inc;
    else if (tick)                     cnt_q <= cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q      <= '0;
      cap_q      <= '0;
      ref_flag_q <= 1'b0;
      cap_flag_q <= 1'b0;
    end else if (run_fall) begin
      ref_q      <= '0;
      cap_q      <= '0;
      ref_flag_q <= 1'b0;
      cap_flag_q <= 1'b0;
    end else begin
      if (wr_ref)  ref_q <= wdata_i[CNT_W-1:0];
      if (cap_stb) cap_q <= cnt_q;
      ref_flag_q <= hit     | (ref_flag_q & ~clr_ref);
      cap_flag_q <= cap_stb | (cap_flag_q & ~clr_cap);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             out_q <= 1'b1;
    else if (!mode_q.run)    out_q <= 1'b1;
    else if (mode_q.toggle)  out_q <= out_q ^ hit;
    else                     out_q <= ~hit;
  end

  assign tmr_pin_o = out_q;
  assign evt_req   = (ref_flag_q && mode_q.ref_req_en) || cap_flag_q;
  assign irq_o     = evt_req && !route_dma_q;
  assign dma_req_o = evt_req && route_dma_q;

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = DATA_W'(mode_q);
      A_REF:   rdata_o = DATA_W'(ref_q);
      A_CAP:   rdata_o = DATA_W'(cap_q);
      A_CNT:   rdata_o = DATA_W'(cnt_q);
      A_EVT:   rdata_o = DATA_W'({cap_flag_q, ref_flag_q});
      A_ROUTE: rdata_o = DATA_W'(route_dma_q);
      default: rdata_o = '0;
    endcase
  end

  AST_HELD_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.run |-> cnt_q == '0); // R4
  AST_CLK_FORCED_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_mode && mode_q.run) |-> mode_q.clk_sel == CLK_STOP); // R5
  AST_REF_FLAG_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_flag_q) |-> $past(hit)); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!mode_q.toggle) && !out_q) |-> $past(hit)); // R8
  AST_TOGGLE_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q.toggle && mode_q.run) && out_q != $past(out_q)) |-> $past(hit)); // R9
  AST_CAP_FLAG_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_flag_q) |-> $past(cap_stb)); // R12

endmodule

// File: tb/test_capcmp_timer.sv
module test_capcmp_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin_in = 1'b0;
  logic        pin_out, irq, dma;
  int          errors = 0;
  int          checks = 0;

  localparam logic [2:0] M = 3'd0, RF = 3'd1, CP = 3'd2, CN = 3'd3, EV = 3'd4, RT = 3'd5;

  always #10 clk = ~clk;

  capcmp_timer i_capcmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tmr_pin_i(pin_in), .tmr_pin_o(pin_out), .irq_o(irq), .dma_req_o(dma)
  );

  function automatic logic [31:0] mk(input logic [7:0] ps, input logic [1:0] ce,
      input logic om, input logic orri, input logic frr, input logic [1:0] cs);
    return {16'h0, ps, ce, om, orri, frr, cs, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic start(input logic [31:0] refv, input logic route, input logic [31:0] mode);
    wr(M, 32'h0);
    wr(RF, refv);
    wr(RT, {31'h0, route});
    wr(M, mode);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 out", {31'h0, pin_out}, 32'h1);
    chk("R1 req", {30'h0, irq, dma}, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    start(32'h0, 1'b0, mk(8'd3, 2'b00, 1'b0, 1'b0, 1'b0, 2'b01));
    repeat (40) @(negedge clk);
    rd(CN, d);
    chk("R2 prescale 3", d, 32'd10);
  endtask

  task automatic t_div16;
    logic [31:0] d;
    start(32'h0, 1'b0, mk(8'd0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b10));
    repeat (160) @(negedge clk);
    rd(CN, d);
    chk("R3 div16", d, 32'd10);
  endtask

  task automatic t_pin_clock;
    logic [31:0] d;
    start(32'h0, 1'b0, mk(8'd0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b11));
    for (int i = 0; i < 5; i++) begin
      pin_in = 1'b1; repeat (3) @(negedge clk);
      pin_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(CN, d);
    chk("R3 pin falls", d, 32'd5);
  endtask

  task automatic t_forced_stop;
    logic [31:0] a, b, m;
    start(32'hFFFF_0000, 1'b0, mk(8'd0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b01));
    repeat (5) @(negedge clk);
    wr(M, mk(8'd0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b01));
    rd(CN, a);
    repeat (10) @(negedge clk);
    rd(CN, b);
    chk("R5 count frozen", b, a);
    rd(M, m);
    chk("R5 clk field", {29'h0, m[2:0]}, 32'h1);
  endtask

  task automatic t_free_pulse;
    logic [31:0] d;
    start(32'd5, 1'b0, mk(8'd0, 2'b00, 1'b0, 1'b1, 1'b0, 2'b01));
    repeat (5) @(negedge clk);
    chk("R8 pulse low", {31'h0, pin_out}, 32'h0);
    chk("R10 irq on ref", {30'h0, irq, dma}, 32'h2);
    rd(EV, d);
    chk("R6 ref flag", d, 32'h1);
    @(negedge clk);
    chk("R8 pulse ends", {31'h0, pin_out}, 32'h1);
    rd(CN, d);
    chk("R6 free run past ref", d, 32'd6);
  endtask

  task automatic t_restart_toggle;
    logic [31:0] d;
    start(32'd4, 1'b0, mk(8'd0, 2'b00, 1'b1, 1'b0, 1'b1, 2'b01));
    repeat (4) @(negedge clk);
    chk("R9 first toggle", {31'h0, pin_out}, 32'h0);
    rd(CN, d);
    chk("R7 restart to zero", d, 32'd0);
    repeat (2) @(negedge clk);
    rd(CN, d);
    chk("R7 recount", d, 32'd2);
    repeat (2) @(negedge clk);
    chk("R9 second toggle", {31'h0, pin_out}, 32'h1);
  endtask

  task automatic t_dma_route;
    start(32'd3, 1'b1, mk(8'd0, 2'b00, 1'b0, 1'b1, 1'b0, 2'b01));
    repeat (8) @(negedge clk);
    chk("R10 dma routed", {30'h0, irq, dma}, 32'h1);
    wr(EV, 32'h1);
    chk("R12 clear ref flag", {30'h0, irq, dma}, 32'h0);
  endtask

  task automatic t_capture_rise;
    logic [31:0] d;
    start(32'd3, 1'b0, mk(8'd0, 2'b01, 1'b0, 1'b0, 1'b0, 2'b01));
    repeat (8) @(negedge clk);
    rd(EV, d);
    chk("R10 ref flag set", d, 32'h1);
    chk("R10 no request with bit4 clear", {30'h0, irq, dma}, 32'h0);
    wr(M, 32'h0);
    start(32'hFFFF_0000, 1'b0, mk(8'd0, 2'b01, 1'b0, 1'b0, 1'b0, 2'b01));
    repeat (4) @(negedge clk);
    pin_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(CP, d);
    chk("R11 rise capture value", d, 32'd6);
    chk("R10 capture irq", {30'h0, irq, dma}, 32'h2);
    pin_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(CP, d);
    chk("R11 fall ignored in rise mode", d, 32'd6);
    wr(EV, 32'h2);
    chk("R12 clear cap flag", {30'h0, irq, dma}, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    start(32'hFFFF_0000, 1'b0, mk(8'd0, 2'b11, 1'b0, 1'b0, 1'b0, 2'b01));
    pin_in = 1'b1;
    repeat (2) @(negedge clk);
    wr(EV, 32'h2);
    rd(EV, d);
    chk("R12 capture beats clear", d, 32'h2);
    rd(CP, d);
    chk("R12 capture value", d, 32'd2);
    pin_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(CP, d);
    chk("R11 both edges falling", d, 32'd5);
  endtask

  task automatic t_fall_only;
    logic [31:0] d;
    start(32'hFFFF_0000, 1'b0, mk(8'd0, 2'b10, 1'b0, 1'b0, 1'b0, 2'b01));
    pin_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(EV, d);
    chk("R11 rise ignored in fall mode", d, 32'h0);
    pin_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(CP, d);
    chk("R11 fall capture value", d, 32'd7);
  endtask

  task automatic t_disable_clears;
    logic [31:0] d;
    wr(M, 32'h0500);
    rd(CN, d);  chk("R4 counter cleared", d, 32'h0);
    rd(CP, d);  chk("R4 capture cleared", d, 32'h0);
    rd(RF, d);  chk("R4 reference cleared", d, 32'h0);
    rd(EV, d);  chk("R4 flags cleared", d, 32'h0);
    rd(M, d);   chk("R4 mode as written", d, 32'h0500);
    repeat (5) @(negedge clk);
    rd(CN, d);  chk("R4 held at zero", d, 32'h0);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_div16();
    t_pin_clock();
    t_forced_stop();
    t_free_pulse();
    t_restart_toggle();
    t_dma_route();
    t_capture_rise();
    t_collision();
    t_fall_only();
    t_disable_clears();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule